// File: doc/BRIEF.md
# Serial Transmitter with Address Bit and Line Pulse

This block turns bytes written by a host into asynchronous serial frames on a single output line. A frame opens with a low start bit, carries 5 to 8 data bits least significant first, and closes with a programmable run of high stop bits. An optional parity bit can follow the data. A second write strobe sends the same byte with one extra address bit set to 1. That bit lets a receiver on a shared multi-drop line tell address words from data words.

A third strobe loads a line-pulse command instead of a byte. The command produces a break or an inter-frame gap of chosen polarity and length in whole bit times, always closed by the configured stop bits. Every word passes through a one-entry holding register before it enters the shift stage. Moving a word out of the holding register can be held off by a clear-to-send input of selectable polarity, or by a software pause bit. A pause never cuts a frame that has already started.

Bit timing comes from an external tick, `halfTick`, which pulses for one clock cycle twice per bit time. Fractional stop lengths are built from this tick. The block has three status outputs: holding register empty, fully empty, and a sticky transmit-finished flag.

Top module: `mdb_uart_tx`

## Requirements
- R1: After reset, and whenever nothing is queued or in flight, `txLine` is 1, `thre` is 1 and `temt` is 1. `txDone` is 0 after reset.
- R2: A `dataWr` frame has these parts, in order: one start bit of 0, then `wordLen`+5 data bits (encoding 0..3 gives 5..8 bits) sent LSB first, then the stop bits. Each non-stop bit lasts two `halfTick` periods. The frame begins at the first `halfTick` after the word is in the holding register. Upper byte bits beyond the word length are not sent.
- R3: An `addrWr` frame carries one extra bit of value 1 directly after the last data bit and before the parity bit. A `dataWr` frame carries no such bit.
- R4: With `parityEn`=1, one parity bit follows the data (and the address bit, if present). With `parityEven`=1 the number of ones across data, address and parity is even. With `parityEven`=0 it is odd.
- R5: `stopSel` 0, 1, 2, 3 gives a high stop period of 1, 1.5, 2 or 2.5 bit times, that is 2, 3, 4 or 5 `halfTick` periods.
- R6: A `pulseWr` command byte drives the line for N = bits 6:0 bit times (2N `halfTick` periods). Bit 7 selects the level: 0 gives a low pulse, 1 gives a high pulse. The configured stop bits follow. No start, data or parity bits are sent. N=0 sends the stop bits only.
- R7: With `autoCts`=1 and CTS inactive, a frame already on the line completes, and the word in the holding register does not start until CTS is active. With `autoCts`=0 the CTS input has no effect.
- R8: With `ctsPolHigh`=0, CTS is active when `ctsIn` is 0. With `ctsPolHigh`=1, CTS is active when `ctsIn` is 1.
- R9: `xoff`=1 holds off the holding-register word in the same way as inactive CTS, whatever the value of `autoCts`.
- R10: `thre` is 0 from an accepted write until the word moves into the shift stage. It is 1 otherwise.
- R11: `temt` is 1 only when the holding register is empty and no frame or stop period is in progress. A word that is waiting when a frame ends starts with no idle gap.
- R12: `txDone` goes to 1 when the last stop period ends with the holding register empty. It stays at 1 until the next accepted write, and it goes to 0 at that write.
- R13: While `txEn`=0, writes are ignored, any frame in progress is aborted, the holding register is emptied and `txLine` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| halfTick | input | 1 | One-cycle pulse, twice per bit time |
| txEn | input | 1 | Transmitter enable |
| dataWr | input | 1 | Write `wrByte` as a plain data word |
| addrWr | input | 1 | Write `wrByte` as an address word |
| pulseWr | input | 1 | Write `wrByte` as a line-pulse command |
| wrByte | input | 8 | Byte for any write strobe |
| wordLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Parity bit enable |
| parityEven | input | 1 | 1 selects even parity, 0 selects odd |
| stopSel | input | 2 | Stop length: 1, 1.5, 2 or 2.5 bits |
| ctsIn | input | 1 | Clear-to-send input |
| ctsPolHigh | input | 1 | 1 makes CTS active-high |
| autoCts | input | 1 | Enables CTS hold-off |
| xoff | input | 1 | Software hold-off |
| txLine | output | 1 | Serial output, idles high |
| thre | output | 1 | Holding register empty |
| temt | output | 1 | Holding and shift stages empty |
| txDone | output | 1 | Sticky transmit-finished flag |

## Verification
The hardest case to reach from the ports is a hold-off that arrives while one word is on the line and a second word is already waiting. The first frame must finish untouched, and only the second must stall. The stimulus gets there by writing the second word one slot after the first has been loaded. It drops CTS on that same slot, lets the scoreboard follow the first frame to its last stop slot, and then checks that the line stays idle with `thre` low. The expected slots for the held word are pushed only when CTS is raised again, so the monitor compares them from the exact slot where the frame must begin.

// File: rtl/mdbtx_pkg.sv
package mdbtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BITS  = 2'd1,
    ST_PULSE = 2'd2,
    ST_STOP  = 2'd3
  } txState_t;

  typedef enum logic [1:0] {
    WK_DATA  = 2'd0,
    WK_ADDR  = 2'd1,
    WK_PULSE = 2'd2
  } wrKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // holding -> shift stage
    logic shift;  // advance to next frame bit
    logic clear;  // transmitter disabled
  } txStrb_t;

  typedef struct packed {
    logic [1:0] wordLen;
    logic       parityEn;
    logic       parityEven;
  } frameCfg_t;

endpackage

// File: rtl/mdbtx_ctrl.sv
module mdbtx_ctrl
  import mdbtx_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             txEn,
  input  logic             pause,
  input  logic             wrAcc,
  input  logic             holdFull,
  input  logic             holdIsPulse,
  input  logic [LEN_W-1:0] holdPulseLen,
  input  logic             lastBit,
  input  logic [1:0]       stopSel,
  output txState_t         state,
  output txStrb_t          strb,
  output logic             done
);

  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] pulseLenQ;
  logic             stopLast;
  logic             pulseLast;
  logic             startNext;

  // stop period spans stopSel+2 half ticks; >= guards a config change mid-stop
  assign stopLast  = (cnt >= (CNT_W'(stopSel) + CNT_W'(1)));
  assign pulseLast = (cnt == ({pulseLenQ, 1'b0} - CNT_W'(1)));

  assign startNext = txEn && halfTick && holdFull && !pause &&
                     ((state == ST_IDLE) || ((state == ST_STOP) && stopLast));

  always_comb begin
    strb.load  = startNext;
    strb.shift = txEn && halfTick && (state == ST_BITS) && (cnt != '0) && !lastBit;
    strb.clear = !txEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pulseLenQ <= '0;
      done      <= 1'b0;
    end else if (!txEn) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      if (startNext) begin
        cnt       <= '0;
        pulseLenQ <= holdPulseLen;
        if (!holdIsPulse)             state <= ST_BITS;
        else if (holdPulseLen == '0)  state <= ST_STOP;
        else                          state <= ST_PULSE;
      end else if (halfTick) begin
        unique case (state)
          ST_BITS: begin
            if (cnt != '0) begin
              cnt <= '0;
              if (lastBit) state <= ST_STOP;
            end else begin
              cnt <= CNT_W'(1);
            end
          end
          ST_PULSE: begin
            if (pulseLast) begin
              cnt   <= '0;
              state <= ST_STOP;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_STOP: begin
            if (stopLast) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
      if (wrAcc)
        done <= 1'b0;
      else if (halfTick && (state == ST_STOP) && stopLast && !holdFull)
        done <= 1'b1;
    end
  end

  // R6
  pulse_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE) |-> (pulseLenQ != '0));

  // R2
  bits_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BITS) |-> (cnt <= CNT_W'(1)));

endmodule

// File: rtl/mdbtx_datapath.sv
module mdbtx_datapath
  import mdbtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrb_t           strb,
  input  txState_t          state,
  input  logic              wrAcc,
  input  wrKind_t           wrKind,
  input  logic [DATA_W-1:0] wrByte,
  input  frameCfg_t         cfg,
  output logic              holdFull,
  output logic              holdIsPulse,
  output logic [LEN_W-1:0]  holdPulseLen,
  output logic              lastBit,
  output logic              txLine
);

  localparam int FRAME_W = DATA_W + 3;             // start + data + address + parity
  localparam int POS_W   = $clog2(FRAME_W + 1);
  localparam int MIN_LEN = DATA_W - 3;

  logic [DATA_W-1:0]  holdByte;
  wrKind_t            holdKind;
  logic [FRAME_W-1:0] shiftQ;
  logic [POS_W-1:0]   bitsLeft;
  logic               pulseLvl;

  logic [FRAME_W-1:0] frmNext;
  logic [POS_W-1:0]   frmLen;
  logic [POS_W-1:0]   dataLen;
  logic               parAcc;

  assign holdIsPulse  = (holdKind == WK_PULSE);
  assign holdPulseLen = holdByte[LEN_W-1:0];
  assign lastBit      = (bitsLeft == POS_W'(1));
  assign dataLen      = POS_W'(cfg.wordLen) + POS_W'(MIN_LEN);

  // holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdByte <= '0;
      holdKind <= WK_DATA;
    end else if (strb.clear) begin
      holdFull <= 1'b0;
    end else if (wrAcc) begin
      holdFull <= 1'b1;
      holdByte <= wrByte;
      holdKind <= wrKind;
    end else if (strb.load) begin
      holdFull <= 1'b0;
    end
  end

  // frame assembly from the held byte and the live configuration
  always_comb begin
    frmNext    = '1;
    frmNext[0] = 1'b0;
    frmLen     = POS_W'(1);
    parAcc     = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (POS_W'(i) < dataLen) begin
        frmNext[frmLen] = holdByte[i];
        parAcc          = parAcc ^ holdByte[i];
        frmLen          = frmLen + POS_W'(1);
      end
    end
    if (holdKind == WK_ADDR) begin
      frmNext[frmLen] = 1'b1;
      parAcc          = ~parAcc;
      frmLen          = frmLen + POS_W'(1);
    end
    if (cfg.parityEn) begin
      frmNext[frmLen] = cfg.parityEven ? parAcc : ~parAcc;
      frmLen          = frmLen + POS_W'(1);
    end
  end

  // shift stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '1;
      bitsLeft <= '0;
      pulseLvl <= 1'b1;
    end else if (strb.clear) begin
      shiftQ   <= '1;
      bitsLeft <= '0;
    end else if (strb.load) begin
      shiftQ   <= frmNext;
      bitsLeft <= frmLen;
      pulseLvl <= holdByte[DATA_W-1];
    end else if (strb.shift) begin
      shiftQ   <= {1'b1, shiftQ[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - POS_W'(1);
    end
  end

  always_comb begin
    unique case (state)
      ST_BITS:  txLine = shiftQ[0];
      ST_PULSE: txLine = pulseLvl;
      default:  txLine = 1'b1;
    endcase
  end

  // R10
  load_needs_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> holdFull);

  // R2
  shift_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> (state == ST_BITS) && (bitsLeft > POS_W'(1)));

endmodule

// File: rtl/mdb_uart_tx.sv
module mdb_uart_tx
  import mdbtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              txEn,
  input  logic              dataWr,
  input  logic              addrWr,
  input  logic              pulseWr,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [1:0]        wordLen,
  input  logic              parityEn,
  input  logic              parityEven,
  input  logic [1:0]        stopSel,
  input  logic              ctsIn,
  input  logic              ctsPolHigh,
  input  logic              autoCts,
  input  logic              xoff,
  output logic              txLine,
  output logic              thre,
  output logic              temt,
  output logic              txDone
);

  txStrb_t          ctlStrb;
  txState_t         state;
  frameCfg_t        cfg;
  wrKind_t          wrKind;
  logic             wrAcc;
  logic             ctsActive;
  logic             pauseNow;
  logic             holdFull;
  logic             holdIsPulse;
  logic [LEN_W-1:0] holdPulseLen;
  logic             lastBit;

  assign ctsActive = ctsPolHigh ? ctsIn : ~ctsIn;
  assign pauseNow  = xoff || (autoCts && !ctsActive);
  assign wrAcc     = txEn && (dataWr || addrWr || pulseWr);
  assign wrKind    = pulseWr ? WK_PULSE : (addrWr ? WK_ADDR : WK_DATA);
  assign cfg       = '{wordLen: wordLen, parityEn: parityEn, parityEven: parityEven};

  mdbtx_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .halfTick     (halfTick),
    .txEn         (txEn),
    .pause        (pauseNow),
    .wrAcc        (wrAcc),
    .holdFull     (holdFull),
    .holdIsPulse  (holdIsPulse),
    .holdPulseLen (holdPulseLen),
    .lastBit      (lastBit),
    .stopSel      (stopSel),
    .state        (state),
    .strb         (ctlStrb),
    .done         (txDone)
  );

  mdbtx_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (ctlStrb),
    .state        (state),
    .wrAcc        (wrAcc),
    .wrKind       (wrKind),
    .wrByte       (wrByte),
    .cfg          (cfg),
    .holdFull     (holdFull),
    .holdIsPulse  (holdIsPulse),
    .holdPulseLen (holdPulseLen),
    .lastBit      (lastBit),
    .txLine       (txLine)
  );

  assign thre = ~holdFull;
  assign temt = ~holdFull && (state == ST_IDLE);

  // R7 R9
  no_start_paused_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrb.load |-> !pauseNow);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    temt |-> txLine);

  // R13
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (txLine && thre));

  // R11
  temt_implies_thre_chk: assert property (@(posedge clk) disable iff (!rstN)
    !thre |-> !temt);

  // R12
  done_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> temt);

  // R2
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(halfTick) && $past(txEn)) |-> $stable(txLine));

endmodule

// File: tb/mdb_uart_tx_tb_top.sv
module mdb_uart_tx_tb_top;

  typedef struct {
    logic  lvl;
    string tag;
  } slot_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b0;
  logic       txEn = 1'b1;
  logic       dataWr = 1'b0, addrWr = 1'b0, pulseWr = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic [1:0] wordLen = 2'd3;
  logic       parityEn = 1'b0, parityEven = 1'b0;
  logic [1:0] stopSel = 2'd0;
  logic       ctsIn = 1'b0, ctsPolHigh = 1'b0, autoCts = 1'b0, xoff = 1'b0;
  logic       txLine, thre, temt, txDone;

  int unsigned cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  slot_t expQ[$];

  always #5 clk = ~clk;

  mdb_uart_tx dut_i (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .txEn(txEn),
    .dataWr(dataWr), .addrWr(addrWr), .pulseWr(pulseWr), .wrByte(wrByte),
    .wordLen(wordLen), .parityEn(parityEn), .parityEven(parityEven),
    .stopSel(stopSel), .ctsIn(ctsIn), .ctsPolHigh(ctsPolHigh),
    .autoCts(autoCts), .xoff(xoff), .txLine(txLine), .thre(thre),
    .temt(temt), .txDone(txDone)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) halfTick <= (cyc % 4 == 0);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // monitor: one sample in the middle of every half-bit slot
  always @(negedge clk) begin
    if (rstN && (cyc % 4 == 2) && !temt && expQ.size() > 0) begin
      slot_t s;
      s = expQ.pop_front();
      chk(txLine === s.lvl, s.tag, int'(txLine), int'(s.lvl));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic atPhase(input int p);
    do @(negedge clk); while (cyc % 4 != p);
  endtask

  task automatic waitSlots(input int n);
    repeat (n) atPhase(2);
  endtask

  task automatic pushSlot(input logic lvl, input string tag);
    slot_t s;
    s.lvl = lvl;
    s.tag = tag;
    expQ.push_back(s);
  endtask

  // kind: 0 data, 1 address, 2 pulse
  task automatic pushFrame(input int kind, input logic [7:0] b, input string tag);
    logic x;
    x = 1'b0;
    if (kind == 2) begin
      for (int i = 0; i < 2 * int'(b[6:0]); i++) pushSlot(b[7], tag);
    end else begin
      pushSlot(1'b0, tag); pushSlot(1'b0, tag);
      for (int i = 0; i < int'(wordLen) + 5; i++) begin
        pushSlot(b[i], tag); pushSlot(b[i], tag);
        x = x ^ b[i];
      end
      if (kind == 1) begin
        pushSlot(1'b1, tag); pushSlot(1'b1, tag);
        x = ~x;
      end
      if (parityEn) begin
        pushSlot(parityEven ? x : ~x, tag);
        pushSlot(parityEven ? x : ~x, tag);
      end
    end
    for (int i = 0; i < int'(stopSel) + 2; i++) pushSlot(1'b1, tag);
  endtask

  task automatic send(input int kind, input logic [7:0] b, input bit push, input string tag);
    atPhase(3);
    wrByte  = b;
    dataWr  = (kind == 0);
    addrWr  = (kind == 1);
    pulseWr = (kind == 2);
    if (push) pushFrame(kind, b, tag);
    @(negedge clk);
    dataWr  = 1'b0;
    addrWr  = 1'b0;
    pulseWr = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    for (int i = 0; i < 3000; i++) begin
      atPhase(2);
      if (temt && expQ.size() == 0) break;
    end
    chk(temt === 1'b1 && expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txLine === 1'b1, "R1 line", int'(txLine), 1);
    chk(thre === 1'b1, "R1 thre", int'(thre), 1);
    chk(temt === 1'b1, "R1 temt", int'(temt), 1);
    chk(txDone === 1'b0, "R1 txDone", int'(txDone), 0);

    // R2 8 data bits, 1 stop; R10 R11 flag timing
    send(0, 8'hA5, 1'b1, "R2 8N1");
    chk(thre === 1'b0, "R10 thre after write", int'(thre), 0);
    chk(temt === 1'b0, "R11 temt after write", int'(temt), 0);
    atPhase(2);
    chk(thre === 1'b1, "R10 thre after load", int'(thre), 1);
    chk(temt === 1'b0, "R11 temt in frame", int'(temt), 0);
    waitIdle("R2 8N1 idle");
    chk(txDone === 1'b1, "R12 txDone set", int'(txDone), 1);

    // R2 other word lengths
    wordLen = 2'd0;
    send(0, 8'hF3, 1'b1, "R2 5-bit");
    waitIdle("R2 5-bit idle");
    wordLen = 2'd2;
    send(0, 8'h5A, 1'b1, "R2 7-bit");
    waitIdle("R2 7-bit idle");

    // R4 parity
    wordLen = 2'd3; parityEn = 1'b1; parityEven = 1'b1;
    send(0, 8'h07, 1'b1, "R4 even");
    waitIdle("R4 even idle");
    parityEven = 1'b0;
    send(0, 8'h07, 1'b1, "R4 odd");
    waitIdle("R4 odd idle");

    // R3 address bit, with and without parity
    parityEven = 1'b1;
    send(1, 8'h3C, 1'b1, "R3 addr even");
    waitIdle("R3 addr idle");
    parityEven = 1'b0;
    send(1, 8'h00, 1'b1, "R3 addr odd");
    waitIdle("R3 addr odd idle");
    parityEn = 1'b0;
    send(1, 8'h81, 1'b1, "R3 addr no parity");
    waitIdle("R3 addr np idle");

    // R5 stop lengths
    for (int s = 1; s < 4; s++) begin
      stopSel = 2'(s);
      send(0, 8'h6E, 1'b1, "R5 stop");
      waitIdle("R5 stop idle");
    end

    // R6 pulses
    send(2, 8'h05, 1'b1, "R6 low pulse");
    waitIdle("R6 low idle");
    send(2, 8'h83, 1'b1, "R6 high pulse");
    waitIdle("R6 high idle");
    send(2, 8'h00, 1'b1, "R6 zero pulse");
    waitIdle("R6 zero idle");
    stopSel = 2'd0;

    // R11 back-to-back, R12 cleared by write
    chk(txDone === 1'b1, "R12 before write", int'(txDone), 1);
    send(0, 8'h12, 1'b1, "R11 first");
    chk(txDone === 1'b0, "R12 cleared by write", int'(txDone), 0);
    send(0, 8'hED, 1'b1, "R11 second");
    chk(thre === 1'b0, "R11 second waits", int'(thre), 0);
    waitIdle("R11 idle");

    // R7 CTS drops while a second word waits
    autoCts = 1'b1; ctsIn = 1'b0;
    send(0, 8'h33, 1'b1, "R7 running frame");
    atPhase(3);
    ctsIn = 1'b1;
    send(0, 8'h44, 1'b0, "R7 held");
    waitSlots(30);
    chk(expQ.size() == 0, "R7 first frame complete", expQ.size(), 0);
    chk(txLine === 1'b1, "R7 line held idle", int'(txLine), 1);
    chk(thre === 1'b0, "R7 word held", int'(thre), 0);
    chk(temt === 1'b0, "R7 temt while held", int'(temt), 0);
    atPhase(3);
    pushFrame(0, 8'h44, "R7 released");
    ctsIn = 1'b0;
    waitIdle("R7 released idle");

    // R7 CTS ignored when automatic mode is off
    autoCts = 1'b0; ctsIn = 1'b1;
    send(0, 8'hC1, 1'b1, "R7 cts ignored");
    waitIdle("R7 ignored idle");

    // R8 active-high CTS
    autoCts = 1'b1; ctsPolHigh = 1'b1; ctsIn = 1'b0;
    send(0, 8'h99, 1'b0, "R8 held");
    waitSlots(6);
    chk(txLine === 1'b1, "R8 line idle", int'(txLine), 1);
    chk(thre === 1'b0, "R8 word held", int'(thre), 0);
    atPhase(3);
    pushFrame(0, 8'h99, "R8 released");
    ctsIn = 1'b1;
    waitIdle("R8 idle");

    // R9 software pause
    autoCts = 1'b0; ctsPolHigh = 1'b0; ctsIn = 1'b0; xoff = 1'b1;
    send(1, 8'h5B, 1'b0, "R9 held");
    waitSlots(6);
    chk(txLine === 1'b1, "R9 line idle", int'(txLine), 1);
    chk(thre === 1'b0, "R9 word held", int'(thre), 0);
    atPhase(3);
    pushFrame(1, 8'h5B, "R9 released");
    xoff = 1'b0;
    waitIdle("R9 idle");

    // R13 disabled writes ignored, abort mid-frame
    txEn = 1'b0;
    send(0, 8'h00, 1'b0, "R13 ignored");
    waitSlots(3);
    chk(thre === 1'b1, "R13 write ignored thre", int'(thre), 1);
    chk(temt === 1'b1, "R13 write ignored temt", int'(temt), 1);
    chk(txLine === 1'b1, "R13 line idle", int'(txLine), 1);
    txEn = 1'b1;
    send(0, 8'h00, 1'b0, "R13 abort");
    send(0, 8'h00, 1'b0, "R13 queued");
    waitSlots(2);
    chk(txLine === 1'b0, "R13 frame running", int'(txLine), 0);
    txEn = 1'b0;
    @(negedge clk);
    chk(txLine === 1'b1, "R13 aborted line", int'(txLine), 1);
    chk(thre === 1'b1, "R13 holding emptied", int'(thre), 1);
    chk(temt === 1'b1, "R13 temt", int'(temt), 1);
    txEn = 1'b1;
    send(0, 8'h96, 1'b1, "R13 recovery");
    waitIdle("R13 recovery idle");

    summary();
    $finish;
  end

endmodule